// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller Core

This block collects up to eight interrupt requests and tells a processor when an unmasked one is waiting. When the processor acknowledges, the block names the vector of the winning request and remembers the request as in service. Software drives it through a byte-wide register port with two addresses. Offset 0 takes the first initialization word and the operation commands. Offset 1 takes the remaining initialization words and, outside initialization, the mask. Reads of offset 0 return either the request or the in-service register, and reads of offset 1 return the mask.

Initialization is a short sequence of words. The first word chooses whether a third and a fourth word follow. The second word is the vector base. Once the sequence is complete, offset-0 writes are decoded as end-of-interrupt commands or as read-back selection. Request lines arrive as separate set and clear strobes, one pair for each input. The pending flag and the read data are registered outputs.

Top module: `pic_core`

## Requirements
- R1: After a synchronous reset, IRR, ISR, IMR, the vector output, the read data and the pending flag are all 0. Offset-0 reads select IRR, and the sequencer waits for the first initialization word.
- R2: Any write to offset 0 with bit 4 set is taken as the first initialization word, in every state. Bit 1 is the single flag and bit 0 is the fourth-word flag. The next offset-1 write is then the vector base and leaves IMR unchanged.
- R3: After the base is written, the sequencer goes to the third-word step if the single flag is 0. If the single flag is 1, it goes to the fourth-word step when the fourth-word flag is 1, and to the ready state otherwise. Every acknowledge vector is the base plus the index of the input granted.
- R4: After the third word, the sequencer goes to the fourth-word step if the fourth-word flag is set, and to the ready state otherwise. After the fourth word it goes to the ready state. Neither word changes IMR.
- R5: An offset-1 write loads IMR when the sequencer is in the ready state or in the post-reset waiting state. An offset-1 read returns IMR.
- R6: A request-set strobe sets its IRR bit and a request-clear strobe clears it. When both strobes hit the same bit in one cycle, the clear wins.
- R7: The pending flag is 1 exactly when IRR AND NOT IMR is nonzero, and it changes on the same clock edge as those registers.
- R8: An acknowledge pulse takes the lowest-numbered unmasked IRR bit. It sets that bit in ISR, clears it in IRR and puts base plus index on the vector output at the next edge. With nothing unmasked, the pulse changes nothing.
- R9: In the ready state, an offset-0 write with bits 7:5 = 011 and bits 4:3 = 00 clears the ISR bit numbered by bits 2:0.
- R10: In the ready state, an offset-0 write with bits 7:5 = 001 and bits 4:3 = 00 clears only the lowest-numbered set ISR bit.
- R11: Offset-0 writes with bits 4:3 = 00 and bits 7:5 = 110 (priority set) or 010 (no-op) change no register.
- R12: In the ready state, an offset-0 write with bits 4:3 = 01 and bit 1 = 1 sets the offset-0 read source: ISR when bit 0 is 1, IRR when bit 0 is 0. With bit 1 = 0 the source is kept.
- R13: An offset-0 write with bit 4 clear, made while the sequencer is not ready, is ignored.
- R14: A register write, an acknowledge and request strobes in the same cycle all take effect. On any bit that both the write and another source touch, the write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register offset (0 or 1) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; data appears after the edge |
| bus_rdata | output | 8 | Registered read data |
| req_set | input | NUM_IRQ | Per-input request set strobes |
| req_clr | input | NUM_IRQ | Per-input request clear strobes |
| intr_ack | input | 1 | Interrupt acknowledge pulse |
| vector | output | 8 | Vector of the last granted request |
| pending | output | 1 | Unmasked request waiting |

## Verification
An acknowledge and an end-of-interrupt command can target the same in-service bit in the same cycle. The bench provokes this by raising the acknowledge together with a specific EOI for the very input being granted. It then expects the vector to update, the request to leave IRR, and the ISR bit to stay clear, because the write wins. Two further collisions are driven as well: a mask write in the same cycle as a request set, where both must land, and a set and a clear on one request bit, where the clear must win. Each result is read back through the register port.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    SEQ_WAIT_ICW1 = 3'd0,
    SEQ_ICW2      = 3'd1,
    SEQ_ICW3      = 3'd2,
    SEQ_ICW4      = 3'd3,
    SEQ_READY     = 3'd4
  } pic_seq_e;
endpackage

// File: rtl/pic_lowest.sv
module pic_lowest #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign onehot = vec & (~vec + N'(1));
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          icw1_wr,
  input  logic          icw1_single,
  input  logic          icw1_ic4,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output pic_seq_e      state_q,
  output logic [DW-1:0] base_q,
  output logic          mask_wr,
  output logic          ready
);
  logic single_q;
  logic ic4_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_WAIT_ICW1;
      single_q <= 1'b0;
      ic4_q    <= 1'b0;
      base_q   <= '0;
    end else if (icw1_wr) begin
      single_q <= icw1_single;
      ic4_q    <= icw1_ic4;
      state_q  <= SEQ_ICW2;
    end else if (data_wr) begin
      case (state_q)
        SEQ_ICW2: begin
          base_q <= wdata;
          if (!single_q)  state_q <= SEQ_ICW3;
          else if (ic4_q) state_q <= SEQ_ICW4;
          else            state_q <= SEQ_READY;
        end
        SEQ_ICW3: state_q <= ic4_q ? SEQ_ICW4 : SEQ_READY;
        SEQ_ICW4: state_q <= SEQ_READY;
        default:  state_q <= state_q;
      endcase
    end
  end

  assign ready   = (state_q == SEQ_READY);
  assign mask_wr = data_wr && ((state_q == SEQ_WAIT_ICW1) || (state_q == SEQ_READY));

  // R2
  icw1_step_chk: assert property (@(posedge clk) disable iff (rst)
    icw1_wr |=> (state_q == SEQ_ICW2));

  // R3
  single_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !icw1_wr && state_q == SEQ_ICW2 && single_q) |=> (state_q != SEQ_ICW3));

  // R4
  icw4_done_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !icw1_wr && state_q == SEQ_ICW4) |=> (state_q == SEQ_READY));
endmodule

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int LW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_wr,
  input  logic [DW-1:0]      wdata,
  input  logic [NUM_IRQ-1:0] isr_q,
  output logic [NUM_IRQ-1:0] eoi_clr,
  output logic               sel_wr,
  output logic               sel_isr
);
  logic is_ocw2, is_ocw3;
  logic f_rot, f_sl, f_eoi;
  logic [NUM_IRQ-1:0] lowest_isr;

  assign is_ocw2 = cmd_wr && !wdata[4] && !wdata[3];
  assign is_ocw3 = cmd_wr && !wdata[4] &&  wdata[3];

  assign f_rot = wdata[7];
  assign f_sl  = wdata[6];
  assign f_eoi = wdata[5];

  assign lowest_isr = isr_q & (~isr_q + NUM_IRQ'(1));

  always_comb begin
    eoi_clr = '0;
    if (is_ocw2 && f_eoi && !f_rot) begin
      if (f_sl) eoi_clr = NUM_IRQ'(1) << wdata[LW-1:0];
      else      eoi_clr = lowest_isr;
    end
  end

  assign sel_wr  = is_ocw3 && wdata[1];
  assign sel_isr = wdata[0];

  // R9
  eoi_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eoi_clr));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_rd,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_IRQ-1:0] req_set,
  input  logic [NUM_IRQ-1:0] req_clr,
  input  logic               intr_ack,
  output logic [7:0]         vector,
  output logic               pending
);
  logic [NUM_IRQ-1:0] irr_q, isr_q, imr_q;
  logic [NUM_IRQ-1:0] irr_n, isr_n, imr_n;
  logic               read_isr_q;
  logic [DW-1:0]      rdata_q, vector_q;
  logic               pending_q;

  logic wr0, wr1, icw1_wr;
  pic_seq_e seq_state;
  logic [DW-1:0] base;
  logic mask_wr, seq_ready;

  logic [NUM_IRQ-1:0] eligible, grant_oh, grant_bit;
  logic [IW-1:0]      grant_idx;
  logic               do_grant;

  logic [NUM_IRQ-1:0] eoi_clr;
  logic sel_wr, sel_isr;

  assign wr0     = bus_wr && !bus_addr;
  assign wr1     = bus_wr &&  bus_addr;
  assign icw1_wr = wr0 && bus_wdata[4];

  pic_init_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .icw1_wr     (icw1_wr),
    .icw1_single (bus_wdata[1]),
    .icw1_ic4    (bus_wdata[0]),
    .data_wr     (wr1),
    .wdata       (bus_wdata),
    .state_q     (seq_state),
    .base_q      (base),
    .mask_wr     (mask_wr),
    .ready       (seq_ready)
  );

  pic_cmd_dec #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .cmd_wr  (wr0 && seq_ready),
    .wdata   (bus_wdata),
    .isr_q   (isr_q),
    .eoi_clr (eoi_clr),
    .sel_wr  (sel_wr),
    .sel_isr (sel_isr)
  );

  assign eligible = irr_q & ~imr_q;

  pic_lowest #(.N(NUM_IRQ)) u_grant (
    .vec    (eligible),
    .onehot (grant_oh),
    .idx    (grant_idx)
  );

  assign do_grant  = intr_ack && (|eligible);
  assign grant_bit = do_grant ? grant_oh : '0;

  always_comb begin
    irr_n = ((irr_q & ~grant_bit) | req_set) & ~req_clr;
    isr_n = (isr_q | grant_bit) & ~eoi_clr;
    imr_n = mask_wr ? bus_wdata[NUM_IRQ-1:0] : imr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q      <= '0;
      isr_q      <= '0;
      imr_q      <= '0;
      read_isr_q <= 1'b0;
      rdata_q    <= '0;
      vector_q   <= '0;
      pending_q  <= 1'b0;
    end else begin
      irr_q     <= irr_n;
      isr_q     <= isr_n;
      imr_q     <= imr_n;
      pending_q <= |(irr_n & ~imr_n);
      if (sel_wr)   read_isr_q <= sel_isr;
      if (do_grant) vector_q   <= base + DW'(grant_idx);
      if (bus_rd) begin
        if (bus_addr)        rdata_q <= DW'(imr_q);
        else if (read_isr_q) rdata_q <= DW'(isr_q);
        else                 rdata_q <= DW'(irr_q);
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign vector    = vector_q;
  assign pending   = pending_q;

  // R7
  pend_chk: assert property (@(posedge clk) disable iff (rst)
    pending_q == (|(irr_q & ~imr_q)));

  // R8
  ack_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (intr_ack && (|(irr_q & ~imr_q)) && !bus_wr) |=> (|(isr_q & ~$past(isr_q))));

  // R6
  clr_win_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_clr) |=> ((irr_q & $past(req_clr)) == '0));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr1 && seq_state == SEQ_READY) |=> (imr_q == $past(bus_wdata[NUM_IRQ-1:0])));
endmodule

// File: tb/pic_core_test.sv
module pic_core_test;
  localparam int OP_WR  = 0;
  localparam int OP_RD  = 1;
  localparam int OP_SET = 2;
  localparam int OP_CLR = 3;
  localparam int OP_ACK = 4;
  localparam int OP_PND = 5;

  function automatic logic [23:0] mk(int tag, int op, int a, int d, int e);
    return {4'(tag), 3'(op), 1'(a), 8'(d), 8'(e)};
  endfunction

  localparam int NV = 71;
  localparam logic [23:0] TBL [NV] = '{
    mk(1, OP_RD, 0, 8'h00, 8'h00),   // R1 IRR after reset
    mk(1, OP_RD, 1, 8'h00, 8'h00),   // R1 IMR after reset
    mk(1, OP_PND, 0, 8'h00, 8'h00),  // R1 pending low
    mk(5, OP_WR, 1, 8'hAA, 8'h00),   // R5 mask in waiting state
    mk(5, OP_RD, 1, 8'h00, 8'hAA),   // R5
    mk(5, OP_WR, 1, 8'h00, 8'h00),   // R5
    mk(2, OP_WR, 0, 8'h11, 8'h00),   // R2 first word, cascade, fourth word
    mk(3, OP_WR, 1, 8'h20, 8'h00),   // R3 base 0x20
    mk(4, OP_WR, 1, 8'h04, 8'h00),   // R4 third word
    mk(4, OP_WR, 1, 8'h01, 8'h00),   // R4 fourth word
    mk(4, OP_RD, 1, 8'h00, 8'h00),   // R4 IMR untouched by init words
    mk(5, OP_WR, 1, 8'h0F, 8'h00),   // R5 mask in ready
    mk(5, OP_RD, 1, 8'h00, 8'h0F),   // R5
    mk(6, OP_SET, 0, 8'h05, 8'h00),  // R6
    mk(7, OP_PND, 0, 8'h00, 8'h00),  // R7 all masked
    mk(12, OP_RD, 0, 8'h00, 8'h05),  // R12 default IRR read
    mk(6, OP_SET, 0, 8'h30, 8'h00),  // R6
    mk(7, OP_PND, 0, 8'h00, 8'h01),  // R7
    mk(8, OP_ACK, 0, 8'h00, 8'h24),  // R8 grant input 4
    mk(12, OP_WR, 0, 8'h0B, 8'h00),  // R12 select ISR
    mk(12, OP_RD, 0, 8'h00, 8'h10),  // R12
    mk(8, OP_ACK, 0, 8'h00, 8'h25),  // R8 grant input 5
    mk(7, OP_PND, 0, 8'h00, 8'h00),  // R7 only masked left
    mk(5, OP_WR, 1, 8'h00, 8'h00),   // R5 unmask
    mk(7, OP_PND, 0, 8'h00, 8'h01),  // R7
    mk(8, OP_ACK, 0, 8'h00, 8'h20),  // R8 grant input 0
    mk(12, OP_RD, 0, 8'h00, 8'h31),  // R12 ISR
    mk(11, OP_WR, 0, 8'hC5, 8'h00),  // R11 priority set
    mk(11, OP_RD, 0, 8'h00, 8'h31),  // R11
    mk(11, OP_WR, 0, 8'h42, 8'h00),  // R11 no-op
    mk(11, OP_RD, 0, 8'h00, 8'h31),  // R11
    mk(10, OP_WR, 0, 8'h20, 8'h00),  // R10 non-specific EOI
    mk(10, OP_RD, 0, 8'h00, 8'h30),  // R10
    mk(9, OP_WR, 0, 8'h65, 8'h00),   // R9 specific EOI level 5
    mk(9, OP_RD, 0, 8'h00, 8'h10),   // R9
    mk(12, OP_WR, 0, 8'h0A, 8'h00),  // R12 select IRR
    mk(12, OP_RD, 0, 8'h00, 8'h04),  // R12
    mk(12, OP_WR, 0, 8'h08, 8'h00),  // R12 bit1 clear keeps source
    mk(12, OP_RD, 0, 8'h00, 8'h04),  // R12
    mk(6, OP_CLR, 0, 8'h04, 8'h00),  // R6 clear strobe
    mk(7, OP_PND, 0, 8'h00, 8'h00),  // R7
    mk(6, OP_RD, 0, 8'h00, 8'h00),   // R6
    mk(8, OP_ACK, 0, 8'h00, 8'h20),  // R8 nothing pending, vector kept
    mk(2, OP_WR, 0, 8'h12, 8'h00),   // R2 single, no fourth word
    mk(3, OP_WR, 1, 8'h40, 8'h00),   // R3 base 0x40
    mk(3, OP_WR, 1, 8'h80, 8'h00),   // R3 now ready: mask
    mk(3, OP_RD, 1, 8'h00, 8'h80),   // R3
    mk(6, OP_SET, 0, 8'h02, 8'h00),  // R6
    mk(3, OP_ACK, 0, 8'h00, 8'h41),  // R3 new base used
    mk(2, OP_WR, 0, 8'h13, 8'h00),   // R2 single, fourth word
    mk(3, OP_WR, 1, 8'h50, 8'h00),   // R3 base 0x50
    mk(4, OP_WR, 1, 8'h00, 8'h00),   // R4 fourth word
    mk(5, OP_WR, 1, 8'h7E, 8'h00),   // R5
    mk(5, OP_RD, 1, 8'h00, 8'h7E),   // R5
    mk(6, OP_SET, 0, 8'h81, 8'h00),  // R6
    mk(3, OP_ACK, 0, 8'h00, 8'h50),  // R3
    mk(2, OP_WR, 0, 8'h10, 8'h00),   // R2 cascade, no fourth word
    mk(13, OP_WR, 0, 8'h0B, 8'h00),  // R13 ignored select
    mk(13, OP_WR, 0, 8'h20, 8'h00),  // R13 ignored EOI
    mk(3, OP_WR, 1, 8'h60, 8'h00),   // R3 base 0x60
    mk(4, OP_WR, 1, 8'h00, 8'h00),   // R4 third word then ready
    mk(5, OP_WR, 1, 8'h00, 8'h00),   // R5 mask
    mk(5, OP_RD, 1, 8'h00, 8'h00),   // R5
    mk(13, OP_RD, 0, 8'h00, 8'h80),  // R13 still IRR source
    mk(13, OP_WR, 0, 8'h0B, 8'h00),  // R12 select ISR
    mk(13, OP_RD, 0, 8'h00, 8'h13),  // R13 ISR untouched
    mk(7, OP_PND, 0, 8'h00, 8'h01),  // R7
    mk(1, OP_PND, 0, 8'h00, 8'h01),  // R7 repeat
    mk(8, OP_RD, 1, 8'h00, 8'h00),   // R5 mask
    mk(8, OP_RD, 0, 8'h00, 8'h13),   // R12 ISR
    mk(8, OP_PND, 0, 8'h00, 8'h01)   // R7
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] req_set = '0;
  logic [7:0] req_clr = '0;
  logic       intr_ack = 1'b0;
  logic [7:0] vector;
  logic       pending;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pic_core uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .req_set(req_set), .req_clr(req_clr), .intr_ack(intr_ack),
    .vector(vector), .pending(pending)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic a, logic [7:0] e);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, e);
  endtask

  task automatic run_op(int tag, int op, logic a, logic [7:0] d, logic [7:0] e);
    string req;
    req = $sformatf("R%0d", tag);
    case (op)
      OP_WR: wr(a, d);
      OP_RD: rd_chk(req, a, e);
      OP_SET: begin req_set = d; @(negedge clk); req_set = '0; end
      OP_CLR: begin req_clr = d; @(negedge clk); req_clr = '0; end
      OP_ACK: begin
        intr_ack = 1'b1; @(negedge clk); intr_ack = 1'b0;
        chk(req, vector, e);
      end
      default: chk(req, {7'd0, pending}, e);
    endcase
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 vector reset", vector, 8'h00);
    chk("R1 rdata reset", bus_rdata, 8'h00);

    for (int k = 0; k < NV; k++) begin
      run_op(int'(TBL[k][23:20]), int'(TBL[k][19:17]), TBL[k][16],
             TBL[k][15:8], TBL[k][7:0]);
    end

    // R14: acknowledge of input 7 with specific EOI of level 7 in one cycle
    intr_ack = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h67;
    @(negedge clk);
    intr_ack = 1'b0; bus_wr = 1'b0;
    chk("R14 vector on collision", vector, 8'h67);
    chk("R14 pending after grant", {7'd0, pending}, 8'h00);
    rd_chk("R14 ISR keeps bit7 clear", 1'b0, 8'h13);

    // R14: mask write and request set in one cycle
    req_set = 8'h04; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h04;
    @(negedge clk);
    req_set = '0; bus_wr = 1'b0;
    chk("R14 masked set not pending", {7'd0, pending}, 8'h00);
    rd_chk("R14 mask landed", 1'b1, 8'h04);
    wr(1'b0, 8'h0A);
    rd_chk("R14 request landed", 1'b0, 8'h04);

    // R6: set and clear of one bit together
    req_set = 8'h08; req_clr = 8'h08;
    @(negedge clk);
    req_set = '0; req_clr = '0;
    rd_chk("R6 clear wins", 1'b0, 8'h04);

    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 pending after reset", {7'd0, pending}, 8'h00);
    chk("R1 vector after reset", vector, 8'h00);
    rd_chk("R1 IRR after reset", 1'b0, 8'h00);
    rd_chk("R1 IMR after reset", 1'b1, 8'h00);
    wr(1'b1, 8'h33);
    rd_chk("R5 mask in waiting state after reset", 1'b1, 8'h33);

    finish_run();
  end
endmodule